// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between two register-bus ports and a 32-entry message-object store. Each entry holds an acceptance mask word, an arbitration word, a message-control word and eight data bytes. Each port owns a set of staging registers that software fills first. Software then writes one command word that names the target object and gives an eight-bit transfer mask.

The command starts a copy between the staging set and the chosen entry. The copy can go in either direction, and it can move any subset of the four field groups. The same transfer can also clear or set the pending flags of the object. While the copy runs, a busy bit in the command register stays high. A driver starts a transfer and polls that bit until it drops.

The two ports run independently. One fixed-priority arbiter lets them share the store. Each transfer holds the store for a fixed number of cycles.

Top module: `msgram_xfer_engine`

## Requirements
- R1: After reset every staging register and command register reads zero, busy is low, and every stored object reads back as all zeros.
- R2: A write to register address 0 is a command. Bits [23:16] hold the transfer mask and bits [5:0] hold the object number, and the write starts a transfer. A read of address 0 returns the last accepted mask in [23:16], busy in bit 15 and the last accepted object number in [5:0]. All other bits read zero.
- R3: When a port is alone, busy reads high for exactly XFER_CYC+1 cycles after the command edge: one cycle waiting for the grant, then XFER_CYC cycles of transfer.
- R4: Mask bit 7 set means write: the staging fields are copied into the entry. Bit 6 selects the mask word (address 1), bit 5 the arbitration word (address 2), bit 4 the control word (address 3), bit 1 data bytes 0-3 (addresses 4-5) and bit 0 data bytes 4-7 (addresses 6-7). Fields that are not selected keep their stored value.
- R5: Mask bit 7 clear means read: the selected entry fields are copied into the staging set, and staging fields that are not selected keep their value.
- R6: Mask bit 3 clears the interrupt-pending flag, bit 13 of the stored control word. It works in both directions. On a write it acts after the control word has been copied.
- R7: Mask bit 2 on a read clears the new-data flag, bit 15 of the stored control word. The staging copy keeps the value from before the clear. Mask bit 2 on a write sets the transmit-request flag, bit 8 of the stored control word.
- R8: Each data register is 16 bits wide. The lower-numbered byte sits in bits [7:0]: address 4 holds bytes 0 and 1, and address 7 holds bytes 6 and 7.
- R9: When both ports have a pending command and the store is free, port 0 is served first. With both commands written on the same edge, port 0 is busy for 4 cycles and port 1 for 8. If both write the same object, the port 1 data is what remains.
- R10: A command naming object 0 or an object above 32 is ignored. Busy stays low, the command register keeps its previous contents, and no entry changes.
- R11: A command written while that port is busy is ignored.
- R12: Staging writes and transfers on one port leave the other port's staging registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 2 | Per-port register write strobe |
| bus_addr | input | 2x3 | Per-port register address |
| bus_wdata | input | 2x32 | Per-port write data |
| bus_rdata | output | 2x32 | Per-port read data, combinational on bus_addr |

## Verification
The bench sweeps all 32 combinations of the five field-select bits. Each combination writes a different object with a distinct arithmetic pattern. A full read-back then separates fields that were written from fields that kept their old value. A partial read into junk-filled staging shows which staging fields the read must leave alone. Flag tests set up control words with new-data and pending bits set, which separates the pre-clear copy in staging from the cleared stored value. Simultaneous commands to one object show the grant order through which data remains. Commands with bad object numbers, and commands written while busy, are followed by reads of every object to show that nothing changed.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef struct packed {
    logic [31:0] msk;
    logic [31:0] arb;
    logic [15:0] ctl;
    logic [63:0] dat;
  } mobj_t;

  localparam int XM_DIR = 7;
  localparam int XM_MSK = 6;
  localparam int XM_ARB = 5;
  localparam int XM_CTL = 4;
  localparam int XM_CIP = 3;
  localparam int XM_NTX = 2;
  localparam int XM_DLO = 1;
  localparam int XM_DHI = 0;

  localparam int CTL_NEWDAT = 15;
  localparam int CTL_INTPND = 13;
  localparam int CTL_TXRQ   = 8;

  typedef enum logic [2:0] {
    RA_CMD = 3'd0, RA_MSK = 3'd1, RA_ARB = 3'd2, RA_CTL = 3'd3,
    RA_D01 = 3'd4, RA_D23 = 3'd5, RA_D45 = 3'd6, RA_D67 = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/mrx_prio_arb.sv
module mrx_prio_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;
  always_comb begin
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !taken;
      taken  = taken | req[i];
    end
  end
endmodule

// File: rtl/mrx_obj_ram.sv
module mrx_obj_ram import mrx_pkg::*; #(
  parameter  int NUM_OBJ = 32,
  localparam int IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  mobj_t            wd,
  output mobj_t            rd
);
  mobj_t mem [NUM_OBJ];

  assign rd = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OBJ; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wd;
    end
  end
endmodule

// File: rtl/mrx_ifc_regs.sv
module mrx_ifc_regs import mrx_pkg::*; #(
  parameter  int NUM_OBJ = 32,
  localparam int OBJ_W   = $clog2(NUM_OBJ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             xfer_done,
  input  logic             stg_load,
  input  mobj_t            stg_next,
  output mobj_t            stg,
  output logic             busy,
  output logic [7:0]       xmask,
  output logic [OBJ_W-1:0] obj
);
  logic             cmd_wr, obj_ok, start, busy_d;
  logic [OBJ_W-1:0] obj_in;
  mobj_t            stg_d;

  assign cmd_wr = bus_we && (bus_addr == RA_CMD);
  assign obj_in = bus_wdata[OBJ_W-1:0];
  assign obj_ok = (obj_in != '0) && (int'(obj_in) <= NUM_OBJ);
  assign start  = cmd_wr && !busy && obj_ok;

  always_comb begin
    busy_d = busy;
    if (start)          busy_d = 1'b1;
    else if (xfer_done) busy_d = 1'b0;
  end

  always_comb begin
    stg_d = stg;
    if (stg_load) begin
      stg_d = stg_next;
    end else if (bus_we) begin
      case (bus_addr)
        RA_MSK:  stg_d.msk        = bus_wdata;
        RA_ARB:  stg_d.arb        = bus_wdata;
        RA_CTL:  stg_d.ctl        = bus_wdata[15:0];
        RA_D01:  stg_d.dat[15:0]  = bus_wdata[15:0];
        RA_D23:  stg_d.dat[31:16] = bus_wdata[15:0];
        RA_D45:  stg_d.dat[47:32] = bus_wdata[15:0];
        RA_D67:  stg_d.dat[63:48] = bus_wdata[15:0];
        default: stg_d = stg;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      RA_CMD:  bus_rdata = {8'h00, xmask, busy, {(15-OBJ_W){1'b0}}, obj};
      RA_MSK:  bus_rdata = stg.msk;
      RA_ARB:  bus_rdata = stg.arb;
      RA_CTL:  bus_rdata = {16'h0, stg.ctl};
      RA_D01:  bus_rdata = {16'h0, stg.dat[15:0]};
      RA_D23:  bus_rdata = {16'h0, stg.dat[31:16]};
      RA_D45:  bus_rdata = {16'h0, stg.dat[47:32]};
      default: bus_rdata = {16'h0, stg.dat[63:48]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      xmask <= '0;
      obj   <= '0;
      stg   <= '0;
    end else begin
      busy <= busy_d;
      stg  <= stg_d;
      if (start) begin
        xmask <= bus_wdata[23:16];
        obj   <= obj_in;
      end
    end
  end

  // R10
  bad_obj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !obj_ok) |=> !busy);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> ($stable(obj) && $stable(xmask) && busy));
  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy);
endmodule

// File: rtl/mrx_xfer_engine.sv
module mrx_xfer_engine import mrx_pkg::*; #(
  parameter  int NUM_IFC  = 2,
  parameter  int NUM_OBJ  = 32,
  parameter  int XFER_CYC = 3,
  localparam int OBJ_W    = $clog2(NUM_OBJ + 1),
  localparam int IDX_W    = $clog2(NUM_OBJ),
  localparam int OWN_W    = (NUM_IFC > 1) ? $clog2(NUM_IFC) : 1,
  localparam int CNT_W    = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IFC-1:0]            req,
  input  logic [NUM_IFC-1:0][7:0]       xmask,
  input  logic [NUM_IFC-1:0][OBJ_W-1:0] obj,
  input  mobj_t                         stg [NUM_IFC],
  input  mobj_t                         ram_rd,
  output logic [IDX_W-1:0]              ram_idx,
  output logic                          ram_we,
  output mobj_t                         ram_wd,
  output logic [NUM_IFC-1:0]            done,
  output logic [NUM_IFC-1:0]            stg_load,
  output mobj_t                         stg_next
);
  logic               active, active_d, last;
  logic [CNT_W-1:0]   cnt, cnt_d;
  logic [OWN_W-1:0]   own, own_d, gnt_idx;
  logic [NUM_IFC-1:0] gnt;
  logic [7:0]         xm;
  mobj_t              s_cur;

  mrx_prio_arb #(.N(NUM_IFC)) u_arb (
    .req (req & {NUM_IFC{!active}}),
    .gnt (gnt)
  );

  always_comb begin
    gnt_idx = '0;
    for (int i = NUM_IFC - 1; i >= 0; i--)
      if (gnt[i]) gnt_idx = OWN_W'(i);
  end

  assign last    = active && (cnt == CNT_W'(XFER_CYC - 1));
  assign xm      = xmask[own];
  assign s_cur   = stg[own];
  assign ram_idx = IDX_W'(obj[own] - OBJ_W'(1));
  assign ram_we  = last;

  always_comb begin
    ram_wd   = ram_rd;
    stg_next = s_cur;
    if (xm[XM_DIR]) begin
      if (xm[XM_MSK]) ram_wd.msk        = s_cur.msk;
      if (xm[XM_ARB]) ram_wd.arb        = s_cur.arb;
      if (xm[XM_CTL]) ram_wd.ctl        = s_cur.ctl;
      if (xm[XM_DLO]) ram_wd.dat[31:0]  = s_cur.dat[31:0];
      if (xm[XM_DHI]) ram_wd.dat[63:32] = s_cur.dat[63:32];
      if (xm[XM_NTX]) ram_wd.ctl[CTL_TXRQ] = 1'b1;
    end else begin
      if (xm[XM_MSK]) stg_next.msk        = ram_rd.msk;
      if (xm[XM_ARB]) stg_next.arb        = ram_rd.arb;
      if (xm[XM_CTL]) stg_next.ctl        = ram_rd.ctl;
      if (xm[XM_DLO]) stg_next.dat[31:0]  = ram_rd.dat[31:0];
      if (xm[XM_DHI]) stg_next.dat[63:32] = ram_rd.dat[63:32];
      if (xm[XM_NTX]) ram_wd.ctl[CTL_NEWDAT] = 1'b0;
    end
    if (xm[XM_CIP]) ram_wd.ctl[CTL_INTPND] = 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_IFC; g++) begin : g_done
      assign done[g]     = last && (own == OWN_W'(g));
      assign stg_load[g] = done[g] && !xm[XM_DIR];
    end
  endgenerate

  always_comb begin
    active_d = active;
    cnt_d    = cnt;
    own_d    = own;
    if (!active && (|gnt)) begin
      active_d = 1'b1;
      cnt_d    = '0;
      own_d    = gnt_idx;
    end else if (active) begin
      if (last) active_d = 1'b0;
      else      cnt_d    = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      own    <= '0;
    end else begin
      active <= active_d;
      cnt    <= cnt_d;
      own    <= own_d;
    end
  end

  // R9
  prio_set1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && req[0]) |=> (active && own == '0));
  // R9
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  // R3
  end_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> !active);
endmodule

// File: rtl/msgram_xfer_engine.sv
module msgram_xfer_engine import mrx_pkg::*; #(
  parameter  int NUM_OBJ  = 32,
  parameter  int XFER_CYC = 3,
  localparam int NUM_IFC  = 2,
  localparam int OBJ_W    = $clog2(NUM_OBJ + 1),
  localparam int IDX_W    = $clog2(NUM_OBJ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IFC-1:0]       bus_we,
  input  logic [NUM_IFC-1:0][2:0]  bus_addr,
  input  logic [NUM_IFC-1:0][31:0] bus_wdata,
  output logic [NUM_IFC-1:0][31:0] bus_rdata
);
  logic                          rst_q1, rst_q2;
  logic [NUM_IFC-1:0]            busy, done, stg_load;
  logic [NUM_IFC-1:0][7:0]       xmask;
  logic [NUM_IFC-1:0][OBJ_W-1:0] obj;
  mobj_t                         stg [NUM_IFC];
  mobj_t                         stg_next, ram_rd, ram_wd;
  logic [IDX_W-1:0]              ram_idx;
  logic                          ram_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_IFC; g++) begin : g_ifc
      mrx_ifc_regs #(.NUM_OBJ(NUM_OBJ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_q2),
        .bus_we    (bus_we[g]),
        .bus_addr  (bus_addr[g]),
        .bus_wdata (bus_wdata[g]),
        .bus_rdata (bus_rdata[g]),
        .xfer_done (done[g]),
        .stg_load  (stg_load[g]),
        .stg_next  (stg_next),
        .stg       (stg[g]),
        .busy      (busy[g]),
        .xmask     (xmask[g]),
        .obj       (obj[g])
      );
    end
  endgenerate

  mrx_xfer_engine #(.NUM_IFC(NUM_IFC), .NUM_OBJ(NUM_OBJ), .XFER_CYC(XFER_CYC)) u_eng (
    .clk      (clk),
    .rst_n    (rst_q2),
    .req      (busy),
    .xmask    (xmask),
    .obj      (obj),
    .stg      (stg),
    .ram_rd   (ram_rd),
    .ram_idx  (ram_idx),
    .ram_we   (ram_we),
    .ram_wd   (ram_wd),
    .done     (done),
    .stg_load (stg_load),
    .stg_next (stg_next)
  );

  mrx_obj_ram #(.NUM_OBJ(NUM_OBJ)) u_ram (
    .clk   (clk),
    .rst_n (rst_q2),
    .idx   (ram_idx),
    .we    (ram_we),
    .wd    (ram_wd),
    .rd    (ram_rd)
  );
endmodule

// File: tb/test_msgram_xfer_engine.sv
module test_msgram_xfer_engine;
  import mrx_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       bus_we;
  logic [1:0][2:0]  bus_addr;
  logic [1:0][31:0] bus_wdata;
  logic [1:0][31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  mobj_t      m_ram [1:32];
  mobj_t      m_stg [2];
  logic [7:0] m_xm  [2];
  logic [5:0] m_obj [2];

  always #10 clk = ~clk;

  msgram_xfer_engine i_msgram_xfer_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_bad++;
        $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc_cnt);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input int p, input logic [2:0] a, output logic [31:0] v);
    bus_addr[p] = a;
    #1;
    v = bus_rdata[p];
  endtask

  task automatic wr(input int p, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we[p] = 1'b1; bus_addr[p] = a; bus_wdata[p] = d;
    @(negedge clk);
    bus_we[p] = 1'b0; bus_addr[p] = 3'd0;
  endtask

  function automatic logic [31:0] reg_exp(input int p, input int a);
    mobj_t s = m_stg[p];
    case (a)
      0: return {8'h00, m_xm[p], 1'b0, 9'h0, m_obj[p]};
      1: return s.msk;
      2: return s.arb;
      3: return {16'h0, s.ctl};
      4: return {16'h0, s.dat[15:0]};
      5: return {16'h0, s.dat[31:16]};
      6: return {16'h0, s.dat[47:32]};
      default: return {16'h0, s.dat[63:48]};
    endcase
  endfunction

  task automatic check_stg(input int p, input string tag);
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(p, 3'(a), v);
      chk($sformatf("%s port%0d reg%0d", tag, p, a), v, reg_exp(p, a));
    end
    bus_addr[p] = 3'd0;
  endtask

  task automatic load_stg(input int p, input mobj_t v);
    wr(p, 3'd1, v.msk);
    wr(p, 3'd2, v.arb);
    wr(p, 3'd3, {16'h0, v.ctl});
    wr(p, 3'd4, {16'h0, v.dat[15:0]});
    wr(p, 3'd5, {16'h0, v.dat[31:16]});
    wr(p, 3'd6, {16'h0, v.dat[47:32]});
    wr(p, 3'd7, {16'h0, v.dat[63:48]});
    m_stg[p] = v;
  endtask

  // Reference model of one accepted command
  task automatic model(input int p, input logic [7:0] xm, input int o);
    mobj_t e, s;
    if (o < 1 || o > 32) return;
    e = m_ram[o]; s = m_stg[p];
    m_xm[p] = xm; m_obj[p] = 6'(o);
    if (xm[7]) begin
      if (xm[6]) e.msk = s.msk;
      if (xm[5]) e.arb = s.arb;
      if (xm[4]) e.ctl = s.ctl;
      if (xm[1]) e.dat[31:0]  = s.dat[31:0];
      if (xm[0]) e.dat[63:32] = s.dat[63:32];
      if (xm[2]) e.ctl[8] = 1'b1;
    end else begin
      if (xm[6]) s.msk = e.msk;
      if (xm[5]) s.arb = e.arb;
      if (xm[4]) s.ctl = e.ctl;
      if (xm[1]) s.dat[31:0]  = e.dat[31:0];
      if (xm[0]) s.dat[63:32] = e.dat[63:32];
      if (xm[2]) e.ctl[15] = 1'b0;
    end
    if (xm[3]) e.ctl[13] = 1'b0;
    m_ram[o] = e; m_stg[p] = s;
  endtask

  task automatic issue(input int p, input logic [7:0] xm, input int o, output int cyc);
    logic [31:0] v;
    @(negedge clk);
    bus_we[p] = 1'b1; bus_addr[p] = 3'd0;
    bus_wdata[p] = {8'h00, xm, 10'h0, 6'(o)};
    @(negedge clk);
    bus_we[p] = 1'b0;
    cyc = 0;
    rd(p, 3'd0, v);
    while (v[15] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      rd(p, 3'd0, v);
    end
    model(p, xm, o);
  endtask

  function automatic mobj_t pat(input int k);
    mobj_t v;
    v.msk = 32'h9E37_79B9 * (k + 1);
    v.arb = 32'h85EB_CA6B ^ (32'(k) << 7) ^ 32'(k);
    v.ctl = 16'(16'h1234 + 16'(k) * 16'h0F31);
    v.dat = {32'hC2B2_AE35 * (k + 3), 32'h27D4_EB2F ^ (32'(k) * 32'h0101_0101)};
    return v;
  endfunction

  function automatic logic [7:0] fbits(input int c);
    return {1'b0, c[4], c[3], c[2], 2'b00, c[1], c[0]};
  endfunction

  initial begin
    int cyc, c0, c1;
    logic [31:0] v;
    mobj_t w;
    bus_we = '0; bus_addr = '0; bus_wdata = '0;
    for (int i = 1; i <= 32; i++) m_ram[i] = '0;
    for (int p = 0; p < 2; p++) begin m_stg[p] = '0; m_xm[p] = '0; m_obj[p] = '0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values of both staging sets and command registers
    check_stg(0, "R1");
    check_stg(1, "R1");
    issue(1, 8'h73, 32, cyc);
    check_stg(1, "R1 stored object zero");

    // R4 R5 R8 R2 R3: sweep of field-select combinations
    for (int c = 0; c < 32; c++) begin
      load_stg(0, pat(c));
      issue(0, 8'h80 | fbits(c), c + 1, cyc);
      chk("R3 solo busy cycles", 32'(cyc), 32'd4);
      check_stg(0, "R2 R4 writer unchanged");
      load_stg(1, pat(c + 100));
      issue(1, fbits(c), c + 1, cyc);
      check_stg(1, "R5 partial read");
      issue(1, 8'h73, c + 1, cyc);
      check_stg(1, "R4 R8 full read");
    end

    // R12: port 0 staging load leaves port 1 untouched
    load_stg(0, pat(200));
    check_stg(1, "R12 other port staging");

    // R6 R7: flag handling on object 7
    w = pat(7); w.ctl = 16'hE4A5;
    load_stg(0, w);
    issue(0, 8'h90, 7, cyc);
    issue(1, 8'h1C, 7, cyc);
    check_stg(1, "R7 pre-clear copy");
    issue(1, 8'h73, 7, cyc);
    check_stg(1, "R6 R7 cleared flags");
    issue(0, 8'h84, 7, cyc);
    issue(1, 8'h73, 7, cyc);
    check_stg(1, "R7 transmit request set");
    issue(0, 8'h90, 7, cyc);
    issue(0, 8'h88, 7, cyc);
    issue(1, 8'h73, 7, cyc);
    check_stg(1, "R6 pending cleared on write");

    // R9: simultaneous commands on one object
    load_stg(0, pat(300));
    load_stg(1, pat(301));
    @(negedge clk);
    bus_we = 2'b11; bus_addr = '0;
    bus_wdata[0] = {8'h00, 8'hF3, 10'h0, 6'd9};
    bus_wdata[1] = {8'h00, 8'hF3, 10'h0, 6'd9};
    @(negedge clk);
    bus_we = 2'b00;
    c0 = 0; c1 = 0;
    for (int t = 0; t < 40; t++) begin
      rd(0, 3'd0, v); if (v[15]) c0++;
      rd(1, 3'd0, v); if (v[15]) c1++;
      @(negedge clk);
    end
    chk("R9 port0 busy cycles", 32'(c0), 32'd4);
    chk("R9 port1 busy cycles", 32'(c1), 32'd8);
    model(0, 8'hF3, 9);
    model(1, 8'hF3, 9);
    issue(0, 8'h73, 9, cyc);
    check_stg(0, "R9 later port data remains");

    // R10: object numbers out of range
    load_stg(1, pat(400));
    issue(1, 8'hF3, 0, cyc);
    chk("R10 obj0 busy", 32'(cyc), 32'd0);
    issue(1, 8'hF3, 33, cyc);
    chk("R10 obj33 busy", 32'(cyc), 32'd0);
    issue(1, 8'hF3, 63, cyc);
    chk("R10 obj63 busy", 32'(cyc), 32'd0);
    check_stg(1, "R10 command register kept");

    // R11: second command while busy
    load_stg(0, pat(500));
    @(negedge clk);
    bus_we[0] = 1'b1; bus_addr[0] = 3'd0;
    bus_wdata[0] = {8'h00, 8'hF3, 10'h0, 6'd10};
    @(negedge clk);
    bus_wdata[0] = {8'h00, 8'hF3, 10'h0, 6'd11};
    @(negedge clk);
    bus_we[0] = 1'b0;
    repeat (10) @(negedge clk);
    model(0, 8'hF3, 10);
    check_stg(0, "R11 first command kept");
    issue(1, 8'h73, 11, cyc);
    check_stg(1, "R11 object 11 untouched");

    // R10 R4: every object holds its expected contents
    for (int o = 1; o <= 32; o++) begin
      issue(0, 8'h73, o, cyc);
      check_stg(0, "R10 final object contents");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule